// File: doc/BRIEF.md
# Temperature-Aware DRAM Refresh Scheduler

This block paces the periodic refresh commands that a DRAM controller must send. The whole array has to be refreshed once in each retention window. That takes 8192 refresh commands in 64 ms at normal temperature, and the window shrinks to 32 ms in the extended range. A free-running interval timer counts one refresh period, and each time it expires it adds one refresh to an owed count. The block asks the command arbiter for a refresh slot whenever anything is owed. Each refresh the arbiter grants clears one owed refresh.

The arbiter may postpone refreshes while the command path is busy. The owed count saturates at a configurable limit, eight by default. At that limit an urgent flag tells the arbiter that no more postponement is safe. A high-temperature input halves the refresh period. The change takes effect at the next timer reload, so a period that is already running is never cut short.

During self-refresh the memory refreshes itself. In that state the scheduler raises no requests, freezes its timer and keeps its owed count. On leaving self-refresh it restarts a full period and owes one extra refresh straight away.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state: `refresh_req`, `refresh_urgent` and `sr_active` are 0, `owed_count` is 0, and the timer restarts a full normal-temperature period.
- R2: With `hot_range` low, `owed_count` rises by one every `BASE_TICKS` clock cycles. After reset the first increment lands on the `BASE_TICKS`-th rising edge following release.
- R3: With `hot_range` high, the period is `BASE_TICKS/2` cycles. The flag is sampled only when the timer reloads, so a change never alters the period already running.
- R4: `refresh_req` is 1 exactly when `owed_count` is non-zero and the block is not in self-refresh.
- R5: An edge where `refresh_ack` and `refresh_req` are both 1 lowers `owed_count` by one. An acknowledge while `refresh_req` is 0 has no effect.
- R6: If an acknowledge and a timer expiry fall on the same edge, `owed_count` stays the same.
- R7: `owed_count` saturates at `OWED_MAX` (8 by default). `refresh_urgent` is 1 exactly when the count equals `OWED_MAX` outside self-refresh.
- R8: A `sr_enter` pulse outside self-refresh sets `sr_active`. While `sr_active` is set:
  - `refresh_req` and `refresh_urgent` are 0.
  - `owed_count` holds.
  - Acknowledges are ignored.
  - The timer is frozen.
- R9: A `sr_exit` pulse in self-refresh clears `sr_active`, adds one to `owed_count` (saturating), and reloads a full period chosen by `hot_range`. The next expiry therefore falls on the period-th edge after the exit edge.
- R10: `sr_enter` while already in self-refresh, and `sr_exit` while not in it, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hot_range | input | 1 | 1 = extended temperature range, halves the refresh period |
| refresh_ack | input | 1 | Arbiter grants one refresh slot this cycle |
| sr_enter | input | 1 | Request to enter self-refresh |
| sr_exit | input | 1 | Request to leave self-refresh |
| refresh_req | output | 1 | At least one refresh is owed |
| refresh_urgent | output | 1 | The postponement limit has been reached |
| sr_active | output | 1 | Block is in self-refresh |
| owed_count | output | $clog2(OWED_MAX+1) | Number of refreshes currently owed |

## Verification
The hardest situations to reach from the ports are the owed count sitting at its ceiling, and a self-refresh exit that has to bump that count and restart the timer. Both need many periods to pass with no grants.

The stimulus therefore switches to the hot range so that periods are short. It withholds acknowledges until the count saturates, enters self-refresh with the count one below the ceiling, and then holds acknowledge and enter high for many cycles. After the exit it drains the count and times the next expiry to the exact edge.

A grant that lands on the same edge as a timer expiry is placed deliberately by counting edges from reset.

// File: rtl/refsched_pkg.sv
// Package: shared types and helpers for the refresh scheduler.
// Assumes: the normal-temperature period is an even number of cycles >= 4.
package refsched_pkg;

    // Self-refresh state of the scheduler
    typedef enum logic {
        SR_OFF = 1'b0,
        SR_ON  = 1'b1
    } sr_state_t;

    // Choose the period in clock cycles from the temperature flag
    function automatic int unsigned period_for(input logic hot, input int unsigned base);
        return hot ? (base / 2) : base;
    endfunction

endpackage

// File: rtl/refsched_interval_timer.sv
// Module: down-counting interval timer. It pulses `tick` once per period.
// Assumes: `run` is low while in self-refresh. `reload` restarts a full period
// and has priority. The temperature flag is sampled only at a reload.
module refsched_interval_timer #(
    parameter int unsigned BASE_TICKS = 390,
    localparam int unsigned CNT_W     = $clog2(BASE_TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic reload,
    input  logic hot,
    output logic tick
);
    import refsched_pkg::*;

    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] next_load;

    // Start value for the next period (period minus one)
    always_comb begin
        next_load = CNT_W'(period_for(hot, BASE_TICKS) - 1);
    end

    // Expiry when the count is exhausted and the timer is running
    always_comb begin
        tick = run && !reload && (remain == '0);
    end

    // Count down, reload at expiry or on request, freeze when not running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= CNT_W'(BASE_TICKS - 1);
        end else if (reload) begin
            remain <= next_load;
        end else if (run) begin
            if (remain == '0) begin
                remain <= next_load;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

endmodule

// File: rtl/refsched_owed_counter.sv
// Module: saturating count of refreshes owed to the array.
// Assumes: `add` and `sub` are single-cycle qualified events; `sub` is only
// asserted when the count is non-zero.
module refsched_owed_counter #(
    parameter int unsigned OWED_MAX = 8,
    localparam int unsigned OW_W    = $clog2(OWED_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            add,
    input  logic            sub,
    output logic [OW_W-1:0] owed
);
    logic at_ceiling;

    // Ceiling detect for saturation
    always_comb begin
        at_ceiling = (owed == OW_W'(OWED_MAX));
    end

    // Update the count: +1 (saturating), -1, or unchanged when both or neither
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else if (add && !sub) begin
            if (!at_ceiling) begin
                owed <= owed + 1'b1;
            end
        end else if (sub && !add) begin
            owed <= owed - 1'b1;
        end
    end

endmodule

// File: rtl/refsched_sr_ctrl.sv
// Module: self-refresh state holder.
// Assumes: enter/exit are level inputs sampled each cycle. An enter request is
// only honoured outside self-refresh, and an exit request only inside it.
module refsched_sr_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_req,
    input  logic exit_req,
    output logic in_sr,
    output logic leaving
);
    import refsched_pkg::*;

    sr_state_t state;

    // Qualified exit event, used by the timer and the owed counter
    always_comb begin
        leaving = (state == SR_ON) && exit_req;
        in_sr   = (state == SR_ON);
    end

    // State transitions for self-refresh entry and exit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SR_OFF;
        end else begin
            case (state)
                SR_OFF:  if (enter_req) state <= SR_ON;
                SR_ON:   if (exit_req)  state <= SR_OFF;
                default: state <= SR_OFF;
            endcase
        end
    end

endmodule

// File: rtl/dram_refresh_sched.sv
// Module: top level of the temperature-aware refresh scheduler.
// It ties the interval timer, the owed counter and the self-refresh control
// together and drives the request/urgent handshake toward the command arbiter.
// Assumes: a single clock domain; refresh_ack is ignored unless refresh_req is high.
module dram_refresh_sched #(
    parameter int unsigned BASE_TICKS = 390,
    parameter int unsigned OWED_MAX   = 8,
    localparam int unsigned OW_W      = $clog2(OWED_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hot_range,
    input  logic            refresh_ack,
    input  logic            sr_enter,
    input  logic            sr_exit,
    output logic            refresh_req,
    output logic            refresh_urgent,
    output logic            sr_active,
    output logic [OW_W-1:0] owed_count
);
    logic in_sr;
    logic leaving;
    logic tick;
    logic grant;

    refsched_sr_ctrl u_sr (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_req (sr_enter),
        .exit_req  (sr_exit),
        .in_sr     (in_sr),
        .leaving   (leaving)
    );

    refsched_interval_timer #(
        .BASE_TICKS (BASE_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (!in_sr),
        .reload (leaving),
        .hot    (hot_range),
        .tick   (tick)
    );

    refsched_owed_counter #(
        .OWED_MAX (OWED_MAX)
    ) u_owed (
        .clk   (clk),
        .rst_n (rst_n),
        .add   (tick || leaving),
        .sub   (grant),
        .owed  (owed_count)
    );

    // Outputs toward the arbiter, suppressed during self-refresh
    always_comb begin
        refresh_req    = !in_sr && (owed_count != '0);
        refresh_urgent = !in_sr && (owed_count == OW_W'(OWED_MAX));
        grant          = refresh_req && refresh_ack;
        sr_active      = in_sr;
    end

endmodule

// File: rtl/refsched_checker.sv
// Module: property checker for the refresh scheduler, attached by bind.
// Assumes: it observes only the top-level ports.
module refsched_checker #(
    parameter int unsigned OWED_MAX = 8,
    localparam int unsigned OW_W    = $clog2(OWED_MAX + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            refresh_ack,
    input logic            sr_enter,
    input logic            sr_exit,
    input logic            refresh_req,
    input logic            refresh_urgent,
    input logic            sr_active,
    input logic [OW_W-1:0] owed_count
);
    p_no_req_in_sr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> (!refresh_req && !refresh_urgent));

    p_no_req_when_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (owed_count == '0) |-> !refresh_req);

    p_owed_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(owed_count) <= int'(OWED_MAX));

    p_urgent_at_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_urgent |-> (int'(owed_count) == int'(OWED_MAX)));

    p_hold_in_sr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_active && !sr_exit) |=> ($stable(owed_count) && sr_active));

    p_exit_bumps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_active && sr_exit) |=> (!sr_active && refresh_req));

    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((int'(owed_count) - int'($past(owed_count)) <= 1) &&
                  (int'($past(owed_count)) - int'(owed_count) <= 1)));

    p_exit_outside_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr_active && !sr_enter) |=> !sr_active);
endmodule

bind dram_refresh_sched refsched_checker #(
    .OWED_MAX (OWED_MAX)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .refresh_ack    (refresh_ack),
    .sr_enter       (sr_enter),
    .sr_exit        (sr_exit),
    .refresh_req    (refresh_req),
    .refresh_urgent (refresh_urgent),
    .sr_active      (sr_active),
    .owed_count     (owed_count)
);

// File: tb/dram_refresh_sched_test.sv
// Bench: a table of timed stimulus phases with expected owed/request values,
// then directed tests for reset, saturation, coincident events and self-refresh.
module dram_refresh_sched_test;
    localparam int unsigned BASE = 20;
    localparam int unsigned OMAX = 8;
    localparam int unsigned OW_W = $clog2(OMAX + 1);

    logic clk = 1'b0;
    logic rst_n;
    logic hot_range;
    logic refresh_ack;
    logic sr_enter;
    logic sr_exit;
    logic refresh_req;
    logic refresh_urgent;
    logic sr_active;
    logic [OW_W-1:0] owed_count;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dram_refresh_sched #(
        .BASE_TICKS (BASE),
        .OWED_MAX   (OMAX)
    ) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .hot_range      (hot_range),
        .refresh_ack    (refresh_ack),
        .sr_enter       (sr_enter),
        .sr_exit        (sr_exit),
        .refresh_req    (refresh_req),
        .refresh_urgent (refresh_urgent),
        .sr_active      (sr_active),
        .owed_count     (owed_count)
    );

    // Vector: {hot, wait_edges[7:0], acks[3:0], exp_owed[3:0], exp_req}
    localparam int NV = 13;
    localparam logic [17:0] VECS [NV] = '{
        {1'b0, 8'd19, 4'd0, 4'd0, 1'b0},   // R2: just before first expiry
        {1'b0, 8'd1,  4'd0, 4'd1, 1'b1},   // R2 R4: first expiry
        {1'b0, 8'd0,  4'd1, 4'd0, 1'b0},   // R5: grant clears it
        {1'b0, 8'd19, 4'd0, 4'd1, 1'b1},   // R2: second expiry
        {1'b1, 8'd5,  4'd0, 4'd1, 1'b1},   // R3: hot mid-period, no effect
        {1'b1, 8'd14, 4'd0, 4'd1, 1'b1},   // R3: running period not shortened
        {1'b1, 8'd1,  4'd0, 4'd2, 1'b1},   // R3: expiry at full period
        {1'b1, 8'd10, 4'd0, 4'd3, 1'b1},   // R3: halved period
        {1'b1, 8'd0,  4'd3, 4'd0, 1'b0},   // R5: three grants
        {1'b0, 8'd6,  4'd0, 4'd0, 1'b0},   // R3: cool mid-period
        {1'b0, 8'd1,  4'd0, 4'd1, 1'b1},   // R3: short period completes
        {1'b0, 8'd19, 4'd0, 4'd1, 1'b1},   // R3: back to full period
        {1'b0, 8'd1,  4'd0, 4'd2, 1'b1}    // R2: expiry
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic grant(input int n);
        for (int i = 0; i < n; i++) begin
            refresh_ack = 1'b1;
            @(negedge clk);
            refresh_ack = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        hot_range = 1'b0;
        refresh_ack = 1'b0;
        sr_enter = 1'b0;
        sr_exit = 1'b0;
        idle(3);
        check("R1 req", int'(refresh_req), 0);
        check("R1 urgent", int'(refresh_urgent), 0);
        check("R1 sr_active", int'(sr_active), 0);
        check("R1 owed", int'(owed_count), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            hot_range = VECS[v][17];
            idle(int'(VECS[v][16:9]));
            grant(int'(VECS[v][8:5]));
            check($sformatf("R2/R3/R5 vec%0d owed", v), int'(owed_count), int'(VECS[v][4:1]));
            check($sformatf("R4 vec%0d req", v), int'(refresh_req), int'(VECS[v][0]));
        end

        // R5: clear, then a grant while nothing is owed is ignored
        grant(2);
        grant(1);
        check("R5 ack ignored owed", int'(owed_count), 0);
        check("R5 ack ignored req", int'(refresh_req), 0);

        // R2: next expiry
        idle(17);
        check("R2 expiry owed", int'(owed_count), 1);

        // R6: grant on the same edge as an expiry
        idle(19);
        grant(1);
        check("R6 coincident owed", int'(owed_count), 1);

        // R7: saturate using short periods
        hot_range = 1'b1;
        idle(79);
        check("R7 below ceiling owed", int'(owed_count), 7);
        check("R7 below ceiling urgent", int'(refresh_urgent), 0);
        idle(1);
        check("R7 ceiling owed", int'(owed_count), 8);
        check("R7 ceiling urgent", int'(refresh_urgent), 1);
        idle(10);
        check("R7 saturate owed", int'(owed_count), 8);
        grant(1);
        check("R7 after grant urgent", int'(refresh_urgent), 0);
        check("R7 after grant owed", int'(owed_count), 7);

        // R8: enter self-refresh
        sr_enter = 1'b1;
        @(negedge clk);
        sr_enter = 1'b0;
        check("R8 sr_active", int'(sr_active), 1);
        check("R8 req", int'(refresh_req), 0);
        check("R8 urgent", int'(refresh_urgent), 0);

        // R8 R10: acks and repeated enters ignored, timer frozen
        refresh_ack = 1'b1;
        sr_enter = 1'b1;
        idle(50);
        refresh_ack = 1'b0;
        sr_enter = 1'b0;
        check("R8 hold owed", int'(owed_count), 7);
        check("R10 still active", int'(sr_active), 1);

        // R9: exit adds one refresh and reloads the timer
        sr_exit = 1'b1;
        @(negedge clk);
        sr_exit = 1'b0;
        check("R9 sr_active", int'(sr_active), 0);
        check("R9 owed", int'(owed_count), 8);
        check("R9 urgent", int'(refresh_urgent), 1);
        grant(8);
        idle(1);
        check("R9 before reload expiry", int'(owed_count), 0);
        idle(1);
        check("R9 reload expiry", int'(owed_count), 1);

        // R10: exit outside self-refresh has no effect
        sr_exit = 1'b1;
        @(negedge clk);
        sr_exit = 1'b0;
        check("R10 exit ignored owed", int'(owed_count), 1);
        check("R10 exit ignored active", int'(sr_active), 0);

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run owed", int'(owed_count), 0);
        check("R1 mid-run req", int'(refresh_req), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule